// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a self-timed flash device and decides when a program or erase operation that is already running has finished. A one-cycle start pulse hands it the address to poll, the byte the operation should leave behind, a poll limit and a mode. It then issues status reads through a simple request/ready/valid read port until the status bits settle. It finishes with a one-cycle done strobe carrying either pass or fail.

Two polling methods share one decision path. In inverted-data mode the top status bit of each read is compared with the same bit of the expected byte. In toggle mode a second status bit is compared between consecutive reads, and a steady value means completion. In both modes a separate error bit is not final on its own. When it appears, the block makes a confirmation read (one in inverted-data mode, two in toggle mode) before it declares failure. For a chip erase the caller passes any address and an expected byte of FFh. For a byte program it passes the programmed address and byte.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, done_o, pass_o, fail_o, busy_o and rd_req_o are all low.
- R2: In inverted-data mode (mode_i = 0), a read whose bit 7 equals bit 7 of the expected byte ends the run with pass, whatever bit 5 holds, and no further read is made.
- R3: In inverted-data mode, a read whose bit 7 differs from the expected bit 7 and whose bit 5 is 0 leads to another read.
- R4: In inverted-data mode, a read whose bit 7 differs and whose bit 5 is 1 leads to exactly one more read. That read ends the run with pass if its bit 7 equals the expected bit, and with fail otherwise.
- R5: In toggle mode (mode_i = 1), the first read only records bit 6. Any later read whose bit 6 equals bit 6 of the read before it ends the run with pass, whatever bit 5 holds.
- R6: In toggle mode, a read whose bit 6 differs from the previous read and whose bit 5 is 0 leads to another read.
- R7: In toggle mode, a read whose bit 6 differs and whose bit 5 is 1 leads to exactly two more reads. The run ends with pass if bit 6 is equal in those two reads, and with fail if it differs.
- R8: Every read of a run presents the address latched at the accepted start.
- R9: Each "keep polling" outcome (R3, R6) is counted. When the count reaches max_polls_i, latched at start, the run ends with fail and no further read is made. A limit of 0 acts like 1.
- R10: done_o is high for exactly one cycle per run, and exactly one of pass_o and fail_o is high with it. Neither is high without done_o.
- R11: A start pulse while busy_o is high is ignored: it does not change the address, mode or outcome of the current run, and it does not start another run.
- R12: rd_req_o stays high with a stable address until rd_ready_i accepts it. Only one read is outstanding at a time, and no new request is raised until the data has returned with rd_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 1 | 0 = inverted-data polling, 1 = toggle polling |
| addr_i | input | AW | Address to poll |
| expect_i | input | DW | Expected final byte (FFh for chip erase) |
| max_polls_i | input | CW | Limit on keep-polling outcomes |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| pass_o | output | 1 | Run completed successfully, with done_o |
| fail_o | output | 1 | Run failed, with done_o |
| rd_req_o | output | 1 | Read request to the bus |
| rd_addr_o | output | AW | Read address |
| rd_ready_i | input | 1 | Bus accepts the request |
| rd_valid_i | input | 1 | Read data is valid |
| rd_data_i | input | DW | Status byte returned by the device |

## Verification
The bench sweeps both modes over every short status script: zero to three busy reads, followed by a settled read, by an error-flagged read whose confirmation succeeds, or by one whose confirmation fails. Both polarities of the expected bit and both toggle starting phases are covered. These scripts separate a completion seen on the first read, one seen after ordinary busy polling, and the two results of the error confirmation. Counting the reads the device model serves shows whether the block stops on time or over-reads. Bus latency and a stalling ready line vary between runs to exercise the handshake. Separate runs hit the poll limit at 0, 2 and 3, and one run pulses start mid-run with a different address and mode.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

   typedef enum logic [2:0] {
      PH_DB_RUN,
      PH_DB_CONF,
      PH_TG_PRIME,
      PH_TG_RUN,
      PH_TG_CPRIME,
      PH_TG_CCMP
   } poll_phase_e;

   typedef enum logic [1:0] {
      ACT_READ,
      ACT_PASS,
      ACT_FAIL
   } poll_act_e;

   typedef struct packed {
      poll_act_e   act;
      poll_phase_e next_ph;
      logic        counted;
   } poll_step_t;

   typedef enum logic [1:0] {
      CS_IDLE,
      CS_ISSUE,
      CS_WAIT
   } ctl_state_e;

   typedef enum logic [1:0] {
      RP_IDLE,
      RP_REQ,
      RP_WAIT
   } rp_state_e;

endpackage

// File: rtl/poll_read_port.sv
module poll_read_port
   import flash_poll_pkg::*;
#(
   parameter int AW = 18,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue_i,
   input  logic [AW-1:0] addr_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_ready_i,
   input  logic          rd_valid_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          rsp_valid_o,
   output logic [DW-1:0] rsp_data_o
);

   rp_state_e     st;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RP_IDLE;
         addr_q <= '0;
      end else begin
         unique case (st)
            RP_IDLE: if (issue_i) begin
               addr_q <= addr_i;
               st     <= RP_REQ;
            end
            RP_REQ:  if (rd_ready_i) st <= RP_WAIT;
            RP_WAIT: if (rd_valid_i) st <= RP_IDLE;
            default: st <= RP_IDLE;
         endcase
      end
   end

   assign rd_req_o    = (st == RP_REQ);
   assign rd_addr_o   = addr_q;
   assign rsp_valid_o = (st == RP_WAIT) && rd_valid_i;
   assign rsp_data_o  = rd_data_i;

endmodule

// File: rtl/poll_decider.sv
module poll_decider
   import flash_poll_pkg::*;
(
   input  poll_phase_e phase_i,
   input  logic        done_bit_i,
   input  logic        tog_bit_i,
   input  logic        err_bit_i,
   input  logic        exp_bit_i,
   input  logic        prev_tog_i,
   output poll_step_t  step_o
);

   always_comb begin
      step_o = '{act: ACT_FAIL, next_ph: phase_i, counted: 1'b0};
      unique case (phase_i)
         PH_DB_RUN: begin
            if (done_bit_i == exp_bit_i)
               step_o.act = ACT_PASS;
            else if (!err_bit_i) begin
               step_o.act     = ACT_READ;
               step_o.counted = 1'b1;
            end else begin
               step_o.act     = ACT_READ;
               step_o.next_ph = PH_DB_CONF;
            end
         end
         PH_DB_CONF:
            step_o.act = (done_bit_i == exp_bit_i) ? ACT_PASS : ACT_FAIL;
         PH_TG_PRIME: begin
            step_o.act     = ACT_READ;
            step_o.next_ph = PH_TG_RUN;
         end
         PH_TG_RUN: begin
            if (tog_bit_i == prev_tog_i)
               step_o.act = ACT_PASS;
            else if (!err_bit_i) begin
               step_o.act     = ACT_READ;
               step_o.counted = 1'b1;
            end else begin
               step_o.act     = ACT_READ;
               step_o.next_ph = PH_TG_CPRIME;
            end
         end
         PH_TG_CPRIME: begin
            step_o.act     = ACT_READ;
            step_o.next_ph = PH_TG_CCMP;
         end
         PH_TG_CCMP:
            step_o.act = (tog_bit_i == prev_tog_i) ? ACT_PASS : ACT_FAIL;
         default: step_o.act = ACT_FAIL;
      endcase
   end

endmodule

// File: rtl/poll_limit.sv
module poll_limit #(
   parameter int CW       = 16,
   parameter bit LIMIT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   input  logic [CW-1:0] max_i,
   output logic          last_o
);

   localparam int XW = CW + 1;

   if (LIMIT_EN) begin : g_lim
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt <= '0;
         else if (clr_i) cnt <= '0;
         else if (inc_i) cnt <= cnt + 1'b1;
      end
      assign last_o = (XW'(cnt) + XW'(1)) >= XW'(max_i);
   end else begin : g_nolim
      logic unused_lim;
      assign unused_lim = ^{clk, rst_n, clr_i, inc_i, max_i};
      assign last_o     = 1'b0;
   end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
   import flash_poll_pkg::*;
#(
   parameter int AW       = 18,
   parameter int DW       = 8,
   parameter int CW       = 16,
   parameter int DONE_BIT = 7,
   parameter int TOG_BIT  = 6,
   parameter int ERR_BIT  = 5,
   parameter bit LIMIT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          mode_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] expect_i,
   input  logic [CW-1:0] max_polls_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          pass_o,
   output logic          fail_o,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_ready_i,
   input  logic          rd_valid_i,
   input  logic [DW-1:0] rd_data_i
);

   if (AW < 1 || CW < 1) begin : g_bad_width
      $error("flash_done_poller: AW and CW must be positive");
   end
   if (DONE_BIT >= DW || TOG_BIT >= DW || ERR_BIT >= DW) begin : g_bad_bitpos
      $error("flash_done_poller: status bit position outside data width");
   end
   if (DONE_BIT == ERR_BIT || TOG_BIT == ERR_BIT) begin : g_bad_overlap
      $error("flash_done_poller: error bit must differ from status bits");
   end

   ctl_state_e    st;
   poll_phase_e   ph;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] max_q;
   logic          exp_bit_q;
   logic          prev_q;
   logic          issue;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   poll_step_t    step;
   logic          lim_last;
   logic          accept;
   logic          unused_bits;

   assign accept      = (st == CS_IDLE) && start_i;
   assign issue       = (st == CS_ISSUE);
   assign busy_o      = (st != CS_IDLE);
   assign unused_bits = ^{expect_i, rsp_data};

   poll_read_port #(.AW(AW), .DW(DW)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_i    (issue),
      .addr_i     (addr_q),
      .rd_req_o   (rd_req_o),
      .rd_addr_o  (rd_addr_o),
      .rd_ready_i (rd_ready_i),
      .rd_valid_i (rd_valid_i),
      .rd_data_i  (rd_data_i),
      .rsp_valid_o(rsp_valid),
      .rsp_data_o (rsp_data)
   );

   poll_decider u_dec (
      .phase_i   (ph),
      .done_bit_i(rsp_data[DONE_BIT]),
      .tog_bit_i (rsp_data[TOG_BIT]),
      .err_bit_i (rsp_data[ERR_BIT]),
      .exp_bit_i (exp_bit_q),
      .prev_tog_i(prev_q),
      .step_o    (step)
   );

   poll_limit #(.CW(CW), .LIMIT_EN(LIMIT_EN)) u_lim (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (accept),
      .inc_i (rsp_valid && (step.act == ACT_READ) && step.counted),
      .max_i (max_q),
      .last_o(lim_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= CS_IDLE;
         ph        <= PH_DB_RUN;
         addr_q    <= '0;
         max_q     <= '0;
         exp_bit_q <= 1'b0;
         prev_q    <= 1'b0;
         done_o    <= 1'b0;
         pass_o    <= 1'b0;
         fail_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         pass_o <= 1'b0;
         fail_o <= 1'b0;
         unique case (st)
            CS_IDLE: if (start_i) begin
               addr_q    <= addr_i;
               max_q     <= max_polls_i;
               exp_bit_q <= expect_i[DONE_BIT];
               ph        <= mode_i ? PH_TG_PRIME : PH_DB_RUN;
               st        <= CS_ISSUE;
            end
            CS_ISSUE: st <= CS_WAIT;
            CS_WAIT: if (rsp_valid) begin
               prev_q <= rsp_data[TOG_BIT];
               if (step.act == ACT_READ) begin
                  if (step.counted && lim_last) begin
                     done_o <= 1'b1;
                     fail_o <= 1'b1;
                     st     <= CS_IDLE;
                  end else begin
                     ph <= step.next_ph;
                     st <= CS_ISSUE;
                  end
               end else begin
                  done_o <= 1'b1;
                  pass_o <= (step.act == ACT_PASS);
                  fail_o <= (step.act != ACT_PASS);
                  st     <= CS_IDLE;
               end
            end
            default: st <= CS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flash_done_poller_chk.sv
module flash_done_poller_chk #(
   parameter int AW = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy_o,
   input logic          done_o,
   input logic          pass_o,
   input logic          fail_o,
   input logic          rd_req_o,
   input logic [AW-1:0] rd_addr_o,
   input logic          rd_ready_i
);

   assert_done_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pass_o ^ fail_o));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_no_stray_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_o || fail_o) |-> done_o);

   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o)));

   assert_req_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_ready_i) |=> !rd_req_o);

   assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && $past(busy_o) && $past(rd_req_o)) |-> $stable(rd_addr_o));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rd_req_o);

endmodule

bind flash_done_poller flash_done_poller_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .pass_o    (pass_o),
   .fail_o    (fail_o),
   .rd_req_o  (rd_req_o),
   .rd_addr_o (rd_addr_o),
   .rd_ready_i(rd_ready_i)
);

// File: tb/flash_done_poller_tb.sv
module flash_done_poller_tb;

   localparam int AW = 18;
   localparam int DW = 8;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          mode_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] expect_i = '0;
   logic [CW-1:0] max_polls_i = '0;
   logic          busy_o, done_o, pass_o, fail_o, rd_req_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_ready_i = 1'b1;
   logic          rd_valid_i = 1'b0;
   logic [DW-1:0] rd_data_i = '0;

   always #5 clk = ~clk;

   flash_done_poller #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .addr_i(addr_i), .expect_i(expect_i), .max_polls_i(max_polls_i),
      .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ready_i(rd_ready_i),
      .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i)
   );

   int n_tests = 0;
   int n_fail  = 0;

   logic [7:0]    script [0:15];
   int            base_idx = 0;
   int            lat_cfg = 0;
   bit            ready_toggle = 1'b0;
   logic [AW-1:0] exp_addr = '0;

   int rd_idx = 0;
   int addr_err = 0;
   int overlap_err = 0;
   bit pending = 1'b0;
   int lat_cnt = 0;

   // device model: serves script bytes in order
   always @(posedge clk) begin
      rd_valid_i <= 1'b0;
      rd_ready_i <= ready_toggle ? ~rd_ready_i : 1'b1;
      if (pending) begin
         if (rd_req_o) overlap_err <= overlap_err + 1;
         if (lat_cnt == 0) begin
            rd_valid_i <= 1'b1;
            rd_data_i  <= script[(rd_idx - base_idx) & 15];
            rd_idx     <= rd_idx + 1;
            pending    <= 1'b0;
         end else begin
            lat_cnt <= lat_cnt - 1;
         end
      end else if (rd_req_o && rd_ready_i) begin
         pending <= 1'b1;
         lat_cnt <= lat_cfg;
         if (rd_addr_o !== exp_addr) addr_err <= addr_err + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reference from the requirements
   task automatic ref_eval(input bit mode, input bit e7, input int maxp,
                           output bit pass, output int nreads);
      int  ph = 0;
      int  cont = 0;
      int  maxe;
      bit  prev = 1'b0;
      bit  fin = 1'b0;
      logic [7:0] d;
      maxe   = (maxp < 1) ? 1 : maxp;
      pass   = 1'b0;
      nreads = 0;
      while (!fin && nreads < 16) begin
         d = script[nreads];
         nreads++;
         if (!mode) begin
            if (ph == 0) begin
               if (d[7] == e7) begin pass = 1'b1; fin = 1'b1; end
               else if (!d[5]) begin
                  cont++;
                  if (cont >= maxe) fin = 1'b1;
               end else ph = 1;
            end else begin
               pass = (d[7] == e7);
               fin  = 1'b1;
            end
         end else begin
            case (ph)
               0: ph = 1;
               1: begin
                  if (d[6] == prev) begin pass = 1'b1; fin = 1'b1; end
                  else if (!d[5]) begin
                     cont++;
                     if (cont >= maxe) fin = 1'b1;
                  end else ph = 2;
               end
               2: ph = 3;
               default: begin pass = (d[6] == prev); fin = 1'b1; end
            endcase
            prev = d[6];
         end
      end
   endtask

   task automatic build_db(input int k, input int endk, input bit e7);
      for (int i = 0; i < 16; i++)
         script[i] = {~e7, i[0], 1'b0, 5'(i + 3)};
      if (k < 16) begin
         if (endk == 0) begin
            script[k][7] = e7;
            script[k][5] = k[0];
         end else begin
            script[k][5]   = 1'b1;
            script[k+1][7] = (endk == 1) ? e7 : ~e7;
         end
      end
   endtask

   task automatic build_tg(input int k, input int endk, input bit p);
      for (int i = 0; i < 16; i++)
         script[i] = {i[1], p ^ i[0], 1'b0, 5'(i)};
      if (k < 16) begin
         if (endk == 0) begin
            script[k+1][6] = script[k][6];
            script[k+1][5] = 1'b1;
         end else begin
            script[k+1][5] = 1'b1;
            script[k+3][6] = (endk == 1) ? script[k+2][6] : ~script[k+2][6];
         end
      end
   endtask

   task automatic run_case(input bit mode, input bit e7, input int maxp,
                           input int lat, input bit rtog, input bit poke,
                           input logic [AW-1:0] addr, input string req);
      bit exp_pass;
      int exp_reads;
      int a0, o0, waited;
      bit seen;
      ref_eval(mode, e7, maxp, exp_pass, exp_reads);
      @(negedge clk);
      base_idx     = rd_idx;
      a0           = addr_err;
      o0           = overlap_err;
      lat_cfg      = lat;
      ready_toggle = rtog;
      exp_addr     = addr;
      addr_i       = addr;
      mode_i       = mode;
      expect_i     = e7 ? 8'hFF : 8'h35;
      max_polls_i  = CW'(maxp);
      start_i      = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin
         repeat (4) @(negedge clk);
         addr_i  = ~addr;
         mode_i  = ~mode;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      seen   = 1'b0;
      waited = 0;
      while (!seen && waited < 2000) begin
         if (done_o) seen = 1'b1;
         else begin
            @(negedge clk);
            waited++;
         end
      end
      chk(seen, "R10", "done seen", int'(seen), 1);
      if (seen) begin
         chk(pass_o == exp_pass && fail_o == !exp_pass, req, "pass flag",
             int'(pass_o), int'(exp_pass));
         chk((rd_idx - base_idx) == exp_reads, req, "read count",
             rd_idx - base_idx, exp_reads);
         @(negedge clk);
         chk(!done_o && !pass_o && !fail_o, "R10", "done width",
             int'(done_o), 0);
      end
      chk(addr_err == a0, "R8", "address errors", addr_err - a0, 0);
      chk(overlap_err == o0, "R12", "overlapping requests", overlap_err - o0, 0);
      if (poke) begin
         bit extra = 1'b0;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (busy_o || done_o || rd_req_o) extra = 1'b1;
         end
         chk(!extra, "R11", "no run from ignored start", int'(extra), 0);
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!done_o && !pass_o && !fail_o && !busy_o && !rd_req_o, "R1",
          "reset outputs", int'({done_o, pass_o, fail_o, busy_o, rd_req_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_o && !busy_o && !rd_req_o, "R1", "idle after reset",
          int'({done_o, busy_o, rd_req_o}), 0);

      // inverted-data sweep
      for (int k = 0; k < 4; k++)
         for (int e = 0; e < 3; e++)
            for (int b = 0; b < 2; b++) begin
               build_db(k, e, b[0]);
               run_case(1'b0, b[0], 15, (k + e) % 3, k[0], 1'b0,
                        AW'(k * 1237 + e * 311 + b * 17),
                        e == 0 ? (k == 0 ? "R2" : "R3") : "R4");
            end

      // toggle sweep
      for (int k = 0; k < 4; k++)
         for (int e = 0; e < 3; e++)
            for (int p = 0; p < 2; p++) begin
               build_tg(k, e, p[0]);
               run_case(1'b1, 1'b1, 15, (k + p) % 3, e[0], 1'b0,
                        AW'(k * 4093 + e * 77 + p * 5),
                        e == 0 ? (k == 0 ? "R5" : "R6") : "R7");
            end

      // poll limit
      build_db(16, 0, 1'b1);
      run_case(1'b0, 1'b1, 3, 1, 1'b0, 1'b0, AW'(18'h3FFFF), "R9");
      build_db(16, 0, 1'b0);
      run_case(1'b0, 1'b0, 0, 0, 1'b1, 1'b0, AW'(18'h00000), "R9");
      build_tg(16, 0, 1'b0);
      run_case(1'b1, 1'b1, 2, 2, 1'b0, 1'b0, AW'(18'h12345), "R9");

      // start while busy
      build_db(3, 0, 1'b1);
      run_case(1'b0, 1'b1, 15, 2, 1'b1, 1'b1, AW'(18'h0A5A5), "R11");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule